// File: doc/BRIEF.md
# Interleaved Partial-Product Multiply Reducer

This block forms the product of a run of N unsigned integer operands, taking one operand per clock cycle even though a multiplier cannot feed its own output back in a single cycle. A single running product would stall the stream for the full multiplier latency on every operand. Instead, the block keeps M independent partial products in a ring. Each accepted operand is multiplied with the partial product that leaves the ring's last slot, and the new value re-enters at slot 0. So any one partial product is touched only once every M accepted operands.

A run begins with a one-cycle `start`, which sets every slot to one. Operands arrive on a valid/data pair, and cycles with `in_valid` low are skipped. When the N-th operand has been accepted, the block spends M cycles folding the M partial products into one value through the same multiplier. It then writes `result` and raises `done` for one cycle. All arithmetic wraps modulo 2^W. The multiplier's pipeline stages are counted as part of the ring, which is why its latency L may not exceed M.

Top module: `interleaved_mul_reducer`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and `result` is 0.
- R2: A cycle with `start` high loads the value 1 into all M slots and begins a new run with an operand count of zero. `start` has priority over `in_valid` in the same cycle.
- R3: After N accepted operands, `result` equals the product of those N operands modulo 2^W (W = 16 by default, N = 128 by default).
- R4: During a run, an operand is accepted in every cycle that `in_valid` is high, including back-to-back cycles, with no stall.
- R5: Cycles of a run with `in_valid` low do not change the outcome, whatever value `in_data` carries.
- R6: `done` rises exactly M cycles after the clock edge that accepts the N-th operand (M = 8 by default), and it stays high for a single cycle.
- R7: `result` changes only in the cycle `done` is high. While the block is idle or reducing, `in_valid` is ignored, and `result` holds its value until the next run completes.
- R8: A `start` during a run discards the partial products of that run. The next result depends only on operands accepted after the restart.
- R9: An operand of zero anywhere in the run makes the result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that opens a new run |
| in_valid | input | 1 | Operand on `in_data` is present this cycle |
| in_data | input | W | Unsigned operand |
| result | output | W | Product of the last completed run, modulo 2^W |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Most operand streams are forced odd. Random even operands would drive a product modulo 2^W to zero and hide a slot that was dropped, duplicated or never set to one. A ring that shifts in the wrong direction or misses a slot during the fold gives a wrong value only when the operands differ per slot, so every stream is pseudo-random. The bench inserts idle cycles carrying junk data into some streams, and it pulses `in_valid` during the fold and after `done`. This catches a design that samples data without qualifying it by state. It also restarts a run midway to expose partial products that survive `start`, and it times `done` against the accepting edge to catch an off-by-one in the fold counter.

// File: rtl/interleaved_mul_reducer.sv
module interleaved_mul_reducer #(
  parameter int W = 16,
  parameter int M = 8,
  parameter int N = 128,
  parameter int L = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] result,
  output logic         done
);

  localparam int CW = $clog2(N + 1);
  localparam int RW = $clog2(M + 1);

  generate
    if (L > M || L < 1 || M < 2) begin : g_bad_cfg
      $error("multiplier latency must be between 1 and M, and M at least 2");
    end
  endgenerate

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RED} state_t;

  state_t        state;
  logic [W-1:0]  slot [M];
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [W-1:0]  acc;

  // slot[0..L-1] stand for the multiplier stages, the rest are plain ring registers
  wire [W-1:0] tail   = slot[M-1];
  wire [W-1:0] mul_b  = (state == S_RED) ? acc : in_data;
  wire [W-1:0] prod   = tail * mul_b;
  wire         accept = (state == S_RUN) && in_valid && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rcnt   <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
      for (int j = 0; j < M; j++) slot[j] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= S_RUN;
        cnt   <= '0;
        for (int j = 0; j < M; j++) slot[j] <= W'(1);
      end else begin
        case (state)
          S_RUN: if (accept) begin
            slot[0] <= prod;
            for (int j = 1; j < M; j++) slot[j] <= slot[j-1];
            if (cnt == CW'(N - 1)) begin
              state <= S_RED;
              rcnt  <= '0;
              acc   <= W'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RED: begin
            acc     <= prod;
            slot[0] <= tail;
            for (int j = 1; j < M; j++) slot[j] <= slot[j-1];
            if (rcnt == RW'(M - 1)) begin
              result <= prod;
              done   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic all_one;
  always_comb begin
    all_one = 1'b1;
    for (int j = 0; j < M; j++) if (slot[j] != W'(1)) all_one = 1'b0;
  end

  p_fresh_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && cnt == '0) |-> all_one);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |-> (cnt < CW'(N)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_from_fold_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == S_RED));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_idle_ignores_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start) |=> (state == S_IDLE && !done));

endmodule

// File: tb/sim_interleaved_mul_reducer.sv
module sim_interleaved_mul_reducer;
  localparam int W = 16;
  localparam int M = 8;
  localparam int N = 128;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] result;
  logic done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  interleaved_mul_reducer #(.W(W), .M(M), .N(N), .L(L)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_data(in_data), .result(result), .done(done));

  // columns: seed, gaps and junk valids, force odd operands, index of a zero operand (-1 none)
  localparam int NV = 6;
  localparam int unsigned VSEED [NV] = '{32'h1234_5678, 32'hdead_beef, 32'h0bad_f00d,
                                         32'h7777_0001, 32'hc0ff_ee00, 32'h0000_0003};
  localparam bit VGAP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam bit VODD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int VZERO [NV] = '{-1, -1, 0, 77, -1, 127};

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned lcg(input int unsigned s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    in_valid = 1'b1;
    in_data = 16'h0;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic run(input int unsigned seed, input bit gaps, input bit odd, input int zpos,
                     input bit all_ones);
    int unsigned s = seed;
    logic [W-1:0] expv = W'(1);
    logic [W-1:0] op;
    int lat = 0;
    pulse_start();
    for (int i = 0; i < N; i++) begin
      s = lcg(s);
      op = all_ones ? W'(1) : s[23:8];
      if (odd) op[0] = 1'b1;
      if (i == zpos) op = '0;
      expv = expv * op;
      if (gaps && s[3]) begin
        in_valid = 1'b0;
        in_data = ~op;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = op;
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int k = 1; k <= M + 3; k++) begin
      if (gaps) begin
        in_valid = 1'b1;
        in_data = W'(k * 911);
      end
      @(negedge clk);
      if (done) begin
        lat = k;
        break;
      end
    end
    chk(lat == M, "R6 latency", W'(lat), W'(M));
    chk(result == expv, zpos >= 0 ? "R9 zero operand" : "R3 product", result, expv);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", W'(done), W'(0));
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1;
      in_data = W'(k + 3);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(result == expv && !done, "R7 hold while idle", result, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 after reset", result, '0);

    // R3 R4 R5 R9: table walk
    for (int v = 0; v < NV; v++) run(VSEED[v], VGAP[v], VODD[v], VZERO[v], 1'b0);

    // R2: all-one stream must give one, so slots were set to one
    run(32'h5, 1'b0, 1'b0, -1, 1'b1);

    // R8: restart midway through a run with junk operands
    pulse_start();
    for (int i = 0; i < 50; i++) begin
      in_valid = 1'b1;
      in_data = W'(2 * i + 3);
      @(negedge clk);
    end
    in_valid = 1'b0;
    run(32'h4242_4242, 1'b0, 1'b1, -1, 1'b0);

    // R2: start with in_valid high must not count as an operand
    run(32'h9999_1111, 1'b1, 1'b1, -1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule